// File: doc/BRIEF.md
# ECC Memory Controller Register File

This block is the software-visible register file of an ECC memory controller. A 32-bit read/write bus reaches nine word registers: memory enable, timing delay, fault status, video configuration, two read-only fault address words, a diagnostic word and two event counters. Bits [5:2] of the address pick the register. The ECC datapath reports a fault on a side-band capture port. That port loads the fault status and both fault address words in one cycle. It can also raise the single interrupt line, which software clears by writing the fault status word.

A parameter selects one of three chip variants. The variant sets the enable-word write mask, the constant code kept in the enable word, and which enable bits live through a soft reset. Only variant 0 has a second, byte-wide diagnostic window with four locations.

There are two resets. The asynchronous power-on reset `porN` loads every register with its initial value. The synchronous soft reset `swRst` reloads the other registers but keeps selected enable bits. Reads are combinational from the current register state.

Top module: `ecc_ctl_regs`

## Requirements
- R1: The word index is `busAddr[5:2]`, mapped as 0 enable, 1 delay, 2 fault status, 3 video config, 4 fault address 0, 5 fault address 1, 6 diagnostic, 7 counter 0 and 8 counter 1. Reads of indices 9 to 15 return 0, and writes to them change nothing.
- R2: After power-on reset, the enable word holds the variant code in bits [31:28] (0x0, 0x1 or 0x2), and all its other bits are 0.
- R3: A write to the enable word stores the written data masked by 0x00000103 in variant 0. In variants 1 and 2 it stores the variant code ORed with the data masked by 0x00000BFF.
- R4: A write to the delay word stores the data with bit 31 forced to 0.
- R5: A bus write to the fault status word stores the written value and drops `irqOut` on the next clock edge.
- R6: Bus writes to indices 4 and 5 are ignored.
- R7: Power-on or soft reset sets the delay word to 0x00000020 and fault address 0 to 0x07C00000. It clears fault status, video config, fault address 1, the diagnostic word, both counters and `irqOut`.
- R8: A soft reset keeps only enable bit 8 in variant 0. In variants 1 and 2 it keeps bits [31:24], [9:2] and 11, and clears the rest.
- R9: In variant 0 only, four byte locations addressed by `diagAddr[1:0]` can be written and read back; they are zero after power-on reset. In variants 1 and 2, `diagRdata` is always 0 and writes are ignored.
- R10: A capture loads fault status, fault address 0 and fault address 1 from the capture inputs. It sets `irqOut` when status bit 3 (uncorrectable) is set, or when status bit 0 (correctable) is set while enable bit 1 is set.
- R11: If any of fault status bits [3:0] is already set when a capture arrives, bit 16 (multiple errors) of the stored status is set.
- R12: Counter 0 and counter 1 are separate registers; a write to index 8 changes only counter 1.
- R13: When a capture and a bus write to the fault status word occur in the same cycle, the capture sets the stored status and the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| swRst | input | 1 | Synchronous soft reset with selective keep |
| busSel | input | 1 | Word aperture access select |
| busWe | input | 1 | Word write enable |
| busAddr | input | 6 | Byte address within the word aperture |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational) |
| diagSel | input | 1 | Byte diagnostic aperture select |
| diagWe | input | 1 | Byte write enable |
| diagAddr | input | 2 | Byte location |
| diagWdata | input | 8 | Byte write data |
| diagRdata | output | 8 | Byte read data |
| capValid | input | 1 | Fault capture strobe |
| capStatus | input | 32 | Captured fault status |
| capAddr0 | input | 32 | Captured fault address word 0 |
| capAddr1 | input | 32 | Captured fault address word 1 |
| irqOut | output | 1 | Fault interrupt |

## Verification
A wrong enable mask or keep mask shows up on the next read of index 0, and the two bench instances set the variant-0 and variant-1 values against each other. A lost capture priority or a missing multiple-error bit is visible one cycle after the capture, on `irqOut` and on a fault status read. A wrong reset value shows up on the first read after the reset edge. A broken decode shows up as a foreign value in an unmapped read, or as a read-only fault address that has changed.

// File: rtl/ecc_regs_pkg.sv
package ecc_regs_pkg;
  localparam int unsigned IDX_ENABLE = 0;
  localparam int unsigned IDX_DELAY  = 1;
  localparam int unsigned IDX_STATUS = 2;
  localparam int unsigned IDX_VIDEO  = 3;
  localparam int unsigned IDX_FADDR0 = 4;
  localparam int unsigned IDX_FADDR1 = 5;
  localparam int unsigned IDX_DIAG   = 6;
  localparam int unsigned IDX_COUNT0 = 7;
  localparam int unsigned IDX_COUNT1 = 8;

  localparam logic [31:0] DELAY_INIT  = 32'h0000_0020;
  localparam logic [31:0] FADDR0_INIT = 32'h07C0_0000;
  localparam logic [31:0] DELAY_MASK  = 32'h7FFF_FFFF;
  localparam int unsigned MULTI_BIT   = 16;

  typedef struct packed {
    logic wrEnable;
    logic wrDelay;
    logic wrStatus;
    logic wrVideo;
    logic wrDiagWord;
    logic wrCount0;
    logic wrCount1;
    logic wrByte;
    logic capture;
    logic softClear;
  } regStrobe_t;

  function automatic logic [31:0] variantCode(input int variant);
    return 32'(variant) << 28;
  endfunction

  function automatic logic [31:0] enableWriteMask(input int variant);
    return (variant == 0) ? 32'h0000_0103 : 32'h0000_0BFF;
  endfunction

  function automatic logic [31:0] enableKeepMask(input int variant);
    return (variant == 0) ? 32'h0000_0100 : 32'hFF00_0BFC;
  endfunction
endpackage

// File: rtl/ecc_regs_ctrl.sv
module ecc_regs_ctrl
  import ecc_regs_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int ADDR_W  = 6,
  localparam int IDX_W  = ADDR_W - 2
) (
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              diagSel,
  input  logic              diagWe,
  input  logic              capValid,
  input  logic              swRst,
  output logic [IDX_W-1:0]  rdIdx,
  output regStrobe_t        strobe
);
  logic wrLive;

  assign rdIdx  = busAddr[ADDR_W-1:2];
  assign wrLive = busSel && busWe && !swRst;

  always_comb begin
    strobe            = '0;
    strobe.softClear  = swRst;
    strobe.capture    = capValid && !swRst;
    strobe.wrEnable   = wrLive && (rdIdx == IDX_W'(IDX_ENABLE));
    strobe.wrDelay    = wrLive && (rdIdx == IDX_W'(IDX_DELAY));
    strobe.wrStatus   = wrLive && (rdIdx == IDX_W'(IDX_STATUS));
    strobe.wrVideo    = wrLive && (rdIdx == IDX_W'(IDX_VIDEO));
    strobe.wrDiagWord = wrLive && (rdIdx == IDX_W'(IDX_DIAG));
    strobe.wrCount0   = wrLive && (rdIdx == IDX_W'(IDX_COUNT0));
    strobe.wrCount1   = wrLive && (rdIdx == IDX_W'(IDX_COUNT1));
    strobe.wrByte     = (VARIANT == 0) && diagSel && diagWe;
  end
endmodule

// File: rtl/ecc_regs_dp.sv
module ecc_regs_dp
  import ecc_regs_pkg::*;
#(
  parameter int VARIANT    = 0,
  parameter int IDX_W      = 4,
  parameter int DIAG_BYTES = 4,
  localparam int DIAG_AW   = $clog2(DIAG_BYTES)
) (
  input  logic               clk,
  input  logic               porN,
  input  regStrobe_t         strobe,
  input  logic [IDX_W-1:0]   rdIdx,
  input  logic [31:0]        wdata,
  input  logic [DIAG_AW-1:0] diagAddr,
  input  logic [7:0]         diagWdata,
  input  logic [31:0]        capStatus,
  input  logic [31:0]        capAddr0,
  input  logic [31:0]        capAddr1,
  output logic [31:0]        busRdata,
  output logic [7:0]         diagRdata,
  output logic               irqOut
);
  localparam logic [31:0] CODE = variantCode(VARIANT);
  localparam logic [31:0] WMSK = enableWriteMask(VARIANT);
  localparam logic [31:0] KEEP = enableKeepMask(VARIANT);

  logic [31:0] enableQ, delayQ, statusQ, videoQ, faddr0Q, faddr1Q;
  logic [31:0] diagWordQ, count0Q, count1Q;
  logic [31:0] enableNext, captureStatus;
  logic        raiseIrq, priorError;

  assign enableNext    = (VARIANT == 0) ? (wdata & WMSK) : (CODE | (wdata & WMSK));
  assign priorError    = |statusQ[3:0];
  assign captureStatus = capStatus | (priorError ? (32'd1 << MULTI_BIT) : 32'd0);
  assign raiseIrq      = capStatus[3] || (capStatus[0] && enableQ[1]);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      enableQ   <= CODE;
      delayQ    <= DELAY_INIT;
      statusQ   <= '0;
      videoQ    <= '0;
      faddr0Q   <= FADDR0_INIT;
      faddr1Q   <= '0;
      diagWordQ <= '0;
      count0Q   <= '0;
      count1Q   <= '0;
      irqOut    <= 1'b0;
    end else if (strobe.softClear) begin
      enableQ   <= enableQ & KEEP;
      delayQ    <= DELAY_INIT;
      statusQ   <= '0;
      videoQ    <= '0;
      faddr0Q   <= FADDR0_INIT;
      faddr1Q   <= '0;
      diagWordQ <= '0;
      count0Q   <= '0;
      count1Q   <= '0;
      irqOut    <= 1'b0;
    end else begin
      if (strobe.wrEnable)   enableQ   <= enableNext;
      if (strobe.wrDelay)    delayQ    <= wdata & DELAY_MASK;
      if (strobe.wrVideo)    videoQ    <= wdata;
      if (strobe.wrDiagWord) diagWordQ <= wdata;
      if (strobe.wrCount0)   count0Q   <= wdata;
      if (strobe.wrCount1)   count1Q   <= wdata;
      if (strobe.capture) begin
        statusQ <= captureStatus;
        faddr0Q <= capAddr0;
        faddr1Q <= capAddr1;
      end else if (strobe.wrStatus) begin
        statusQ <= wdata;
      end
      if (strobe.capture && raiseIrq) irqOut <= 1'b1;
      else if (strobe.wrStatus)       irqOut <= 1'b0;
    end
  end

  always_comb begin
    case (rdIdx)
      IDX_W'(IDX_ENABLE): busRdata = enableQ;
      IDX_W'(IDX_DELAY):  busRdata = delayQ;
      IDX_W'(IDX_STATUS): busRdata = statusQ;
      IDX_W'(IDX_VIDEO):  busRdata = videoQ;
      IDX_W'(IDX_FADDR0): busRdata = faddr0Q;
      IDX_W'(IDX_FADDR1): busRdata = faddr1Q;
      IDX_W'(IDX_DIAG):   busRdata = diagWordQ;
      IDX_W'(IDX_COUNT0): busRdata = count0Q;
      IDX_W'(IDX_COUNT1): busRdata = count1Q;
      default:            busRdata = '0;
    endcase
  end

  generate
    if (VARIANT == 0) begin : gByteWindow
      logic [7:0] byteMem [DIAG_BYTES];
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) begin
          for (int i = 0; i < DIAG_BYTES; i++) byteMem[i] <= '0;
        end else if (strobe.wrByte) begin
          byteMem[diagAddr] <= diagWdata;
        end
      end
      assign diagRdata = byteMem[diagAddr];
    end else begin : gNoWindow
      logic unusedDiag;
      assign unusedDiag = ^{diagAddr, diagWdata, strobe.wrByte};
      assign diagRdata  = '0;
    end
  endgenerate
endmodule

// File: rtl/ecc_ctl_regs.sv
module ecc_ctl_regs
  import ecc_regs_pkg::*;
#(
  parameter int VARIANT    = 0,
  parameter int ADDR_W     = 6,
  parameter int DIAG_BYTES = 4,
  localparam int IDX_W     = ADDR_W - 2,
  localparam int DIAG_AW   = $clog2(DIAG_BYTES)
) (
  input  logic               clk,
  input  logic               porN,
  input  logic               swRst,
  input  logic               busSel,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic               diagSel,
  input  logic               diagWe,
  input  logic [DIAG_AW-1:0] diagAddr,
  input  logic [7:0]         diagWdata,
  output logic [7:0]         diagRdata,
  input  logic               capValid,
  input  logic [31:0]        capStatus,
  input  logic [31:0]        capAddr0,
  input  logic [31:0]        capAddr1,
  output logic               irqOut
);
  regStrobe_t       strobe;
  logic [IDX_W-1:0] rdIdx;

  ecc_regs_ctrl #(.VARIANT(VARIANT), .ADDR_W(ADDR_W)) uCtrl (
    .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .diagSel(diagSel), .diagWe(diagWe), .capValid(capValid),
    .swRst(swRst), .rdIdx(rdIdx), .strobe(strobe)
  );

  ecc_regs_dp #(.VARIANT(VARIANT), .IDX_W(IDX_W), .DIAG_BYTES(DIAG_BYTES)) uDp (
    .clk(clk), .porN(porN), .strobe(strobe), .rdIdx(rdIdx),
    .wdata(busWdata), .diagAddr(diagAddr), .diagWdata(diagWdata),
    .capStatus(capStatus), .capAddr0(capAddr0), .capAddr1(capAddr1),
    .busRdata(busRdata), .diagRdata(diagRdata), .irqOut(irqOut)
  );
endmodule

// File: rtl/ecc_regs_chk.sv
module ecc_regs_chk #(
  parameter int VARIANT = 0,
  parameter int ADDR_W  = 6
) (
  input logic              clk,
  input logic              porN,
  input logic              swRst,
  input logic              busSel,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busRdata,
  input logic              diagSel,
  input logic [7:0]        diagRdata,
  input logic              capValid,
  input logic [31:0]       capStatus,
  input logic              irqOut
);
  logic [ADDR_W-3:0] idx;
  logic              rdCyc;
  assign idx   = busAddr[ADDR_W-1:2];
  assign rdCyc = busSel && !busWe;

  assert_unmapped_zero_R1: assert property (@(posedge clk) disable iff (!porN)
    rdCyc && (idx > 8) |-> busRdata == 32'd0);

  assert_delay_msb_clear_R4: assert property (@(posedge clk) disable iff (!porN)
    rdCyc && (idx == 1) |-> busRdata[31] == 1'b0);

  assert_status_write_clears_irq_R5: assert property (@(posedge clk) disable iff (!porN)
    busSel && busWe && (idx == 2) && !capValid && !swRst |=> !irqOut);

  assert_uncorrectable_raises_irq_R10: assert property (@(posedge clk) disable iff (!porN)
    capValid && capStatus[3] && !swRst |=> irqOut);

  assert_soft_reset_delay_R7: assert property (@(posedge clk) disable iff (!porN)
    $past(swRst) && rdCyc && (idx == 1) |-> busRdata == 32'h0000_0020);

  assert_soft_reset_irq_low_R7: assert property (@(posedge clk) disable iff (!porN)
    swRst |=> !irqOut);

  assert_no_window_R9: assert property (@(posedge clk) disable iff (!porN)
    (VARIANT != 0) && diagSel |-> diagRdata == 8'd0);
endmodule

bind ecc_ctl_regs ecc_regs_chk #(.VARIANT(VARIANT), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .porN(porN), .swRst(swRst), .busSel(busSel), .busWe(busWe),
  .busAddr(busAddr), .busRdata(busRdata), .diagSel(diagSel),
  .diagRdata(diagRdata), .capValid(capValid), .capStatus(capStatus),
  .irqOut(irqOut)
);

// File: tb/sim_ecc_ctl_regs.sv
`timescale 1ns/1ps
module sim_ecc_ctl_regs;
  logic clk = 1'b0;
  logic porN = 1'b0, swRst = 1'b0;
  logic busSel = 1'b0, busWe = 1'b0;
  logic [5:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic diagSel = 1'b0, diagWe = 1'b0;
  logic [1:0] diagAddr = '0;
  logic [7:0] diagWdata = '0;
  logic capValid = 1'b0;
  logic [31:0] capStatus = '0, capAddr0 = '0, capAddr1 = '0;
  logic [31:0] rdata0, rdata1;
  logic [7:0]  drd0, drd1;
  logic        irq0, irq1;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ecc_ctl_regs #(.VARIANT(0)) u0 (
    .clk(clk), .porN(porN), .swRst(swRst), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdata0),
    .diagSel(diagSel), .diagWe(diagWe), .diagAddr(diagAddr),
    .diagWdata(diagWdata), .diagRdata(drd0), .capValid(capValid),
    .capStatus(capStatus), .capAddr0(capAddr0), .capAddr1(capAddr1),
    .irqOut(irq0));

  ecc_ctl_regs #(.VARIANT(1)) u1 (
    .clk(clk), .porN(porN), .swRst(swRst), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdata1),
    .diagSel(diagSel), .diagWe(diagWe), .diagAddr(diagAddr),
    .diagWdata(diagWdata), .diagRdata(drd1), .capValid(capValid),
    .capStatus(capStatus), .capAddr0(capAddr0), .capAddr1(capAddr1),
    .irqOut(irq1));

  // {index, write data, expected variant 0, expected variant 1}
  localparam int NVEC = 11;
  localparam logic [99:0] VEC [NVEC] = '{
    {4'd0, 32'hFFFF_FFFF, 32'h0000_0103, 32'h1000_0BFF},  // R3
    {4'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF},  // R4
    {4'd3, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 32'hA5A5_A5A5},  // R1
    {4'd6, 32'h1234_5678, 32'h1234_5678, 32'h1234_5678},  // R1
    {4'd7, 32'hCAFE_F00D, 32'hCAFE_F00D, 32'hCAFE_F00D},  // R1
    {4'd8, 32'h0BAD_BEEF, 32'h0BAD_BEEF, 32'h0BAD_BEEF},  // R12
    {4'd2, 32'h0003_FFFF, 32'h0003_FFFF, 32'h0003_FFFF},  // R5
    {4'd4, 32'hFFFF_FFFF, 32'h07C0_0000, 32'h07C0_0000},  // R6
    {4'd5, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000},  // R6
    {4'd9, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000},  // R1
    {4'd0, 32'h0000_0002, 32'h0000_0002, 32'h1000_0002}   // R3
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = {idx, 2'b00}; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] a0, output logic [31:0] a1);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b0; busAddr = {idx, 2'b00};
    #2;
    a0 = rdata0; a1 = rdata1;
    busSel = 1'b0;
  endtask

  task automatic rdBoth(input string tag, input logic [3:0] idx, input logic [31:0] e0, input logic [31:0] e1);
    logic [31:0] a0, a1;
    rd(idx, a0, a1);
    check({tag, " v0"}, a0, e0);
    check({tag, " v1"}, a1, e1);
  endtask

  task automatic cap(input logic [31:0] st);
    @(negedge clk);
    capValid = 1'b1; capStatus = st; capAddr0 = 32'h1111_1111; capAddr1 = 32'h2222_2222;
    @(negedge clk);
    capValid = 1'b0;
  endtask

  task automatic checkIrq(input string tag, input logic exp);
    check({tag, " irq v0"}, {31'd0, irq0}, {31'd0, exp});
    check({tag, " irq v1"}, {31'd0, irq1}, {31'd0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    porN = 1'b1;
    // power-on state
    rdBoth("R2 enable after power-on", 4'd0, 32'h0, 32'h1000_0000);
    rdBoth("R7 delay after power-on", 4'd1, 32'h20, 32'h20);
    rdBoth("R7 faddr0 after power-on", 4'd4, 32'h07C0_0000, 32'h07C0_0000);
    checkIrq("R7 power-on", 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][99:96], VEC[i][95:64]);
      rdBoth($sformatf("vector %0d R1/R3/R4/R6/R12", i), VEC[i][99:96], VEC[i][63:32], VEC[i][31:0]);
    end

    // capture without interrupt-on-correctable
    wr(4'd2, 32'h0);
    wr(4'd0, 32'h0);
    cap(32'h1);
    checkIrq("R10 correctable masked", 1'b0);
    rdBoth("R10 status load", 4'd2, 32'h1, 32'h1);
    rdBoth("R10 faddr0 load", 4'd4, 32'h1111_1111, 32'h1111_1111);
    rdBoth("R10 faddr1 load", 4'd5, 32'h2222_2222, 32'h2222_2222);
    cap(32'h1);
    rdBoth("R11 multiple errors", 4'd2, 32'h0001_0001, 32'h0001_0001);

    wr(4'd0, 32'h2);
    cap(32'h1);
    checkIrq("R10 correctable enabled", 1'b1);
    wr(4'd2, 32'h0);
    checkIrq("R5 status write clears", 1'b0);
    rdBoth("R5 status stored", 4'd2, 32'h0, 32'h0);
    cap(32'h8);
    checkIrq("R10 uncorrectable", 1'b1);
    wr(4'd2, 32'h0);

    // same-cycle capture and status write
    @(negedge clk);
    capValid = 1'b1; capStatus = 32'h8;
    busSel = 1'b1; busWe = 1'b1; busAddr = {4'd2, 2'b00}; busWdata = 32'hFFFF;
    @(negedge clk);
    capValid = 1'b0; busSel = 1'b0; busWe = 1'b0;
    checkIrq("R13 capture wins", 1'b1);
    rdBoth("R13 capture status wins", 4'd2, 32'h8, 32'h8);
    wr(4'd2, 32'h0);

    wr(4'd4, 32'hDEAD_BEEF);
    wr(4'd5, 32'hDEAD_BEEF);
    rdBoth("R6 faddr0 read-only", 4'd4, 32'h1111_1111, 32'h1111_1111);
    rdBoth("R6 faddr1 read-only", 4'd5, 32'h2222_2222, 32'h2222_2222);

    wr(4'd7, 32'h1);
    wr(4'd8, 32'h2);
    rdBoth("R12 counter0 kept", 4'd7, 32'h1, 32'h1);
    rdBoth("R12 counter1 written", 4'd8, 32'h2, 32'h2);

    // soft reset with selective keep
    wr(4'd0, 32'hFFFF_FFFF);
    cap(32'h8);
    @(negedge clk); swRst = 1'b1;
    @(negedge clk); swRst = 1'b0;
    checkIrq("R7 soft reset", 1'b0);
    rdBoth("R8 enable keep", 4'd0, 32'h0000_0100, 32'h1000_0BFC);
    rdBoth("R7 delay", 4'd1, 32'h20, 32'h20);
    rdBoth("R7 status", 4'd2, 32'h0, 32'h0);
    rdBoth("R7 video", 4'd3, 32'h0, 32'h0);
    rdBoth("R7 faddr0", 4'd4, 32'h07C0_0000, 32'h07C0_0000);
    rdBoth("R7 faddr1", 4'd5, 32'h0, 32'h0);
    rdBoth("R7 diag word", 4'd6, 32'h0, 32'h0);
    rdBoth("R7 counter0", 4'd7, 32'h0, 32'h0);
    rdBoth("R7 counter1", 4'd8, 32'h0, 32'h0);

    // byte diagnostic window
    @(negedge clk);
    diagSel = 1'b1; diagWe = 1'b1; diagAddr = 2'd2; diagWdata = 8'h5A;
    @(negedge clk);
    diagWe = 1'b0;
    #2;
    check("R9 byte write v0", {24'd0, drd0}, 32'h5A);
    check("R9 no window v1", {24'd0, drd1}, 32'h0);
    diagAddr = 2'd1;
    #2;
    check("R9 other byte untouched v0", {24'd0, drd0}, 32'h0);
    diagSel = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule